// File: doc/BRIEF.md
# Two-Class Masked Interrupt Controller

This block gathers thirty-two level-sensitive request lines into a single raw status word. It keeps two separate enable masks over that word, one for the normal interrupt class and one for the fast interrupt class. A request output for each class goes high whenever any raw bit that the class has enabled is set. Neither class latches edges, ranks sources by priority or supplies a vector: software reads the masked status word of the class that fired and services the bits it finds there.

Software reaches the block through a small register port with a byte address, a write strobe, a write word and a read word that responds in the same cycle. Software never writes a mask word directly. Each class has a write-one-to-set location, which is also where that mask reads back, and a write-only write-one-to-clear location. Two raw positions do not come from the hardware lines. The error-summary bit is the OR of a separate error vector, and the software-interrupt bit copies a one-bit register that software can read and write. Several raw positions are reserved and are held at zero in every view.

Top module: `dual_class_intc`

## Requirements
- R1: Reset clears both enable masks and the software-interrupt bit. After reset both request outputs are low and the mask and software registers read zero, whatever the source inputs are.
- R2: Offset 0x00 returns the raw word. In it, bit 0 is the software-interrupt bit and bit 1 is the OR of every bit of the error vector. Every other live bit follows the hardware line at the same position. Hardware lines 0 and 1 are ignored.
- R3: A write to 0x10 sets the normal-class enable bits where the data holds 1, and a write to 0x0C does the same for the fast class. Bits written as 0 keep their value. A read of the same offset returns the current mask, and the new value is visible after one clock edge.
- R4: A write to 0x18 clears the normal-class enable bits where the data holds 1, and a write to 0x14 does the same for the fast class. Bits written as 0 keep their value. If a set and a clear of the same bit ever meet in one cycle, the clear wins.
- R5: Offset 0x08 reads the raw word ANDed with the normal-class mask, and offset 0x04 reads the raw word ANDed with the fast-class mask.
- R6: `irq_o` is high exactly when the normal-class masked word is non-zero, and `fiq_o` is high exactly when the fast-class masked word is non-zero. Both follow the source inputs in the same cycle.
- R7: Offset 0x54 holds the software-interrupt bit at bit 0, which can be read and written, and bits 31..1 read as zero. While the bit is 1, raw bit 0 is 1.
- R8: Positions 11, 20..23 and 28..31 are reserved. They read as zero in the raw word, both masked words and both masks, and writes cannot set them.
- R9: Reads of 0x14, 0x18 and any unmapped offset return zero. Writes to unmapped offsets and to the read-only status offsets change no state.
- R10: Writing one class's set or clear location leaves the other class's mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_src_i | input | 32 | Level-sensitive hardware request lines, one per raw position |
| err_stat_i | input | ERR_W (8) | Error vector, OR-reduced into raw bit 1 |
| bus_addr_i | input | ADDR_W (8) | Register byte offset |
| bus_we_i | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Normal-class request |
| fiq_o | output | 1 | Fast-class request |

## Verification
The read word and both request outputs are combinational. They are due in the same cycle that the source inputs or the address change, so the bench moves those inputs on a falling edge and samples one nanosecond later. A register write becomes visible only after the single rising edge that captures it. The bench therefore holds each write strobe across exactly one rising edge, drops it at the next falling edge, and only then sets the read address and samples. Reset checks are sampled after reset is released, with every source line driven high, so that a mask which failed to clear would show up on the outputs.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int SRC_W   = 32;
  localparam int NCLS    = 2;
  localparam int CLS_IRQ = 0;
  localparam int CLS_FIQ = 1;

  // raw word positions that carry a source; everything else is reserved
  localparam logic [SRC_W-1:0] LIVE_BITS = 32'h0F0F_F7FF;
  localparam int SRC_SOFT = 0;
  localparam int SRC_ERR  = 1;
  // live positions that are fed by hardware lines (bits 0 and 1 are internal)
  localparam logic [SRC_W-1:0] HW_BITS = LIVE_BITS & ~32'h0000_0003;

  localparam int OFF_RAW  = 'h00;
  localparam int OFF_SOFT = 'h54;

  // masked-status read offset per class
  function automatic int stat_off(input int cls);
    return (cls == CLS_IRQ) ? 'h08 : 'h04;
  endfunction

  // set / mask-readback offset per class
  function automatic int en_off(input int cls);
    return (cls == CLS_IRQ) ? 'h10 : 'h0C;
  endfunction

  // write-only clear offset per class
  function automatic int clr_off(input int cls);
    return (cls == CLS_IRQ) ? 'h18 : 'h14;
  endfunction

  // next mask value: set first, then clear wins, reserved forced to zero
  function automatic logic [SRC_W-1:0] next_mask(input logic [SRC_W-1:0] cur,
                                                 input logic [SRC_W-1:0] setv,
                                                 input logic [SRC_W-1:0] clrv);
    return ((cur | setv) & ~clrv) & LIVE_BITS;
  endfunction

  function automatic logic [SRC_W-1:0] gate(input logic [SRC_W-1:0] raw,
                                            input logic [SRC_W-1:0] mask);
    return raw & mask;
  endfunction

  function automatic logic any_set(input logic [SRC_W-1:0] v);
    return |v;
  endfunction

endpackage

// File: rtl/intc_src_gather.sv
module intc_src_gather
  import intc_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic [SRC_W-1:0] hw_src_i,
  input  logic [ERR_W-1:0] err_stat_i,
  input  logic             soft_i,
  output logic [SRC_W-1:0] raw_o
);

  logic err_sum;
  logic [SRC_W-1:0] internal_bits;

  assign err_sum = |err_stat_i;

  always_comb begin
    internal_bits           = '0;
    internal_bits[SRC_SOFT] = soft_i;
    internal_bits[SRC_ERR]  = err_sum;
  end

  assign raw_o = (hw_src_i & HW_BITS) | internal_bits;

endmodule

// File: rtl/intc_mask_bank.sv
module intc_mask_bank
  import intc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] set_i,
  input  logic [SRC_W-1:0] clr_i,
  input  logic [SRC_W-1:0] raw_i,
  output logic [SRC_W-1:0] mask_o,
  output logic [SRC_W-1:0] pend_o,
  output logic             req_o
);

  logic [SRC_W-1:0] mask_q;
  logic             touched;

  assign touched = any_set(set_i) || any_set(clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (touched) mask_q <= next_mask(mask_q, set_i, clr_i);
  end

  assign mask_o = mask_q;
  assign pend_o = gate(raw_i, mask_q);
  assign req_o  = any_set(pend_o);

  // R3: every live bit set (and not cleared) last cycle is now enabled
  p_set_sticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q & $past(set_i & ~clr_i & LIVE_BITS)) == $past(set_i & ~clr_i & LIVE_BITS)));

  // R4: every bit cleared last cycle is now disabled, even if also set
  p_clr_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q & $past(clr_i)) == '0));

  // R10: no write to this class, no change
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!touched) |=> $stable(mask_q));

endmodule

// File: rtl/intc_bus_regs.sv
module intc_bus_regs
  import intc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        we_i,
  input  logic [SRC_W-1:0]            wdata_i,
  input  logic [SRC_W-1:0]            raw_i,
  input  logic [NCLS-1:0][SRC_W-1:0]  mask_i,
  input  logic [NCLS-1:0][SRC_W-1:0]  pend_i,
  output logic [NCLS-1:0][SRC_W-1:0]  set_o,
  output logic [NCLS-1:0][SRC_W-1:0]  clr_o,
  output logic                        soft_o,
  output logic [SRC_W-1:0]            rdata_o
);

  logic hit_soft;
  logic hit_raw;
  logic [NCLS-1:0] hit_en;
  logic [NCLS-1:0] hit_stat;
  logic [NCLS-1:0] hit_clr;
  logic soft_q;

  assign hit_soft = (addr_i == ADDR_W'(OFF_SOFT));
  assign hit_raw  = (addr_i == ADDR_W'(OFF_RAW));

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    assign hit_en[c]   = (addr_i == ADDR_W'(en_off(c)));
    assign hit_stat[c] = (addr_i == ADDR_W'(stat_off(c)));
    assign hit_clr[c]  = (addr_i == ADDR_W'(clr_off(c)));
    assign set_o[c]    = (we_i && hit_en[c])  ? wdata_i : '0;
    assign clr_o[c]    = (we_i && hit_clr[c]) ? wdata_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                soft_q <= 1'b0;
    else if (we_i && hit_soft) soft_q <= wdata_i[0];
  end

  assign soft_o = soft_q;

  always_comb begin
    rdata_o = '0;
    if (hit_raw)  rdata_o = raw_i;
    if (hit_soft) rdata_o = {{(SRC_W-1){1'b0}}, soft_q};
    for (int c = 0; c < NCLS; c++) begin
      if (hit_en[c])   rdata_o = mask_i[c];
      if (hit_stat[c]) rdata_o = pend_i[c];
    end
  end

  // R7: the software bit takes the written value after one edge
  p_soft_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && hit_soft) |=> (soft_o == $past(wdata_i[0])));

  // R9: write-only clear locations read as zero
  p_wo_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_clr) |-> (rdata_o == '0));

endmodule

// File: rtl/dual_class_intc.sv
module dual_class_intc
  import intc_pkg::*;
#(
  parameter int ERR_W  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       hw_src_i,
  input  logic [ERR_W-1:0]  err_stat_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);

  logic [SRC_W-1:0]           raw_word;
  logic                       soft_bit;
  logic [NCLS-1:0][SRC_W-1:0] set_vec;
  logic [NCLS-1:0][SRC_W-1:0] clr_vec;
  logic [NCLS-1:0][SRC_W-1:0] mask_vec;
  logic [NCLS-1:0][SRC_W-1:0] pend_vec;
  logic [NCLS-1:0]            req_vec;

  intc_src_gather #(.ERR_W(ERR_W)) u_gather (
    .hw_src_i   (hw_src_i),
    .err_stat_i (err_stat_i),
    .soft_i     (soft_bit),
    .raw_o      (raw_word)
  );

  intc_bus_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (bus_addr_i),
    .we_i    (bus_we_i),
    .wdata_i (bus_wdata_i),
    .raw_i   (raw_word),
    .mask_i  (mask_vec),
    .pend_i  (pend_vec),
    .set_o   (set_vec),
    .clr_o   (clr_vec),
    .soft_o  (soft_bit),
    .rdata_o (bus_rdata_o)
  );

  for (genvar c = 0; c < NCLS; c++) begin : g_bank
    intc_mask_bank u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec[c]),
      .clr_i  (clr_vec[c]),
      .raw_i  (raw_word),
      .mask_o (mask_vec[c]),
      .pend_o (pend_vec[c]),
      .req_o  (req_vec[c])
    );
  end

  assign irq_o = req_vec[CLS_IRQ];
  assign fiq_o = req_vec[CLS_FIQ];

  // R7: the software register drives raw bit 0
  p_soft_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_bit |-> raw_word[SRC_SOFT]);

  // R2: any error bit raises the summary source
  p_err_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_stat_i) |-> raw_word[SRC_ERR]);

  // R8: reserved positions stay zero in the raw word and in both masks
  p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_word | mask_vec[CLS_IRQ] | mask_vec[CLS_FIQ]) & ~LIVE_BITS) == '0);

  // R6: a non-zero masked read implies the matching request line
  p_irq_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == ADDR_W'(stat_off(CLS_IRQ)) && bus_rdata_o != '0) |-> irq_o);

  p_fiq_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == ADDR_W'(stat_off(CLS_FIQ)) && bus_rdata_o != '0) |-> fiq_o);

  // R1: the cycle after reset releases, nothing is enabled
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (mask_vec == '0 && !soft_bit));

endmodule

// File: tb/tb_dual_class_intc.sv
`timescale 1ns/1ps
module tb_dual_class_intc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] hw_src_i = '0;
  logic [7:0]  err_stat_i = '0;
  logic [7:0]  bus_addr_i = '0;
  logic        bus_we_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o, fiq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_class_intc dut (
    .clk(clk), .rst_n(rst_n), .hw_src_i(hw_src_i), .err_stat_i(err_stat_i),
    .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  waddr;
    logic [31:0] wdata;
    logic [31:0] hw;
    logic [7:0]  err;
    logic [7:0]  raddr;
    logic [31:0] exp;
    logic        eirq;
    logic        efiq;
    logic [7:0]  req;
  } row_t;

  localparam int NROW = 21;
  localparam row_t TBL [NROW] = '{
    '{1'b0, 8'h00, 32'h0,          32'hFFFF_FFFF, 8'h00, 8'h00, 32'h0F0F_F7FC, 1'b0, 1'b0, 8'd2},  // R2 R8
    '{1'b1, 8'h10, 32'h0000_00F0,  32'hFFFF_FFFF, 8'h00, 8'h10, 32'h0000_00F0, 1'b1, 1'b0, 8'd3},  // R3 R6
    '{1'b0, 8'h00, 32'h0,          32'hFFFF_FFFF, 8'h00, 8'h0C, 32'h0,         1'b1, 1'b0, 8'd10}, // R10
    '{1'b1, 8'h0C, 32'hFFFF_FFFF,  32'hFFFF_FFFF, 8'h00, 8'h0C, 32'h0F0F_F7FF, 1'b1, 1'b1, 8'd8},  // R8 R3
    '{1'b1, 8'h14, 32'h0000_FFFF,  32'hFFFF_FFFF, 8'h00, 8'h0C, 32'h0F0F_0000, 1'b1, 1'b1, 8'd4},  // R4
    '{1'b0, 8'h00, 32'h0,          32'h0000_0030, 8'h00, 8'h08, 32'h0000_0030, 1'b1, 1'b0, 8'd5},  // R5
    '{1'b0, 8'h00, 32'h0,          32'h0100_0030, 8'h00, 8'h04, 32'h0100_0000, 1'b1, 1'b1, 8'd5},  // R5
    '{1'b1, 8'h18, 32'hFFFF_FFFF,  32'h0100_0030, 8'h00, 8'h10, 32'h0,         1'b0, 1'b1, 8'd4},  // R4 R10
    '{1'b0, 8'h00, 32'h0,          32'h0,         8'h04, 8'h00, 32'h0000_0002, 1'b0, 1'b0, 8'd2},  // R2
    '{1'b1, 8'h0C, 32'h0000_0002,  32'h0,         8'h04, 8'h04, 32'h0000_0002, 1'b0, 1'b1, 8'd6},  // R6
    '{1'b1, 8'h54, 32'hFFFF_FFFF,  32'h0,         8'h00, 8'h54, 32'h0000_0001, 1'b0, 1'b0, 8'd7},  // R7
    '{1'b0, 8'h00, 32'h0,          32'h0,         8'h00, 8'h00, 32'h0000_0001, 1'b0, 1'b0, 8'd7},  // R7
    '{1'b1, 8'h10, 32'h0000_0001,  32'h0,         8'h00, 8'h08, 32'h0000_0001, 1'b1, 1'b0, 8'd6},  // R6
    '{1'b1, 8'h10, 32'h0,          32'h0,         8'h00, 8'h10, 32'h0000_0001, 1'b1, 1'b0, 8'd3},  // R3
    '{1'b0, 8'h00, 32'h0,          32'h0,         8'h00, 8'h14, 32'h0,         1'b1, 1'b0, 8'd9},  // R9
    '{1'b0, 8'h00, 32'h0,          32'h0,         8'h00, 8'h18, 32'h0,         1'b1, 1'b0, 8'd9},  // R9
    '{1'b1, 8'h40, 32'hFFFF_FFFF,  32'h0,         8'h00, 8'h40, 32'h0,         1'b1, 1'b0, 8'd9},  // R9
    '{1'b1, 8'h00, 32'h0,          32'h0,         8'h00, 8'h10, 32'h0000_0001, 1'b1, 1'b0, 8'd9},  // R9
    '{1'b0, 8'h00, 32'h0,          32'h0,         8'h00, 8'h0C, 32'h0F0F_0002, 1'b1, 1'b0, 8'd9},  // R9
    '{1'b1, 8'h54, 32'h0,          32'h0,         8'h00, 8'h54, 32'h0,         1'b0, 1'b0, 8'd7},  // R7
    '{1'b1, 8'h08, 32'hFFFF_FFFF,  32'h0,         8'h00, 8'h10, 32'h0000_0001, 1'b0, 1'b0, 8'd9}   // R9
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(negedge clk);
    bus_we_i = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #1;
    d = bus_rdata_o;
  endtask

  task automatic reset_checks(input string tag);
    logic [31:0] v;
    hw_src_i = 32'hFFFF_FFFF; err_stat_i = 8'hFF;
    bus_read(8'h10, v); check({tag, " irq mask"}, v, 32'h0);
    bus_read(8'h0C, v); check({tag, " fiq mask"}, v, 32'h0);
    bus_read(8'h54, v); check({tag, " soft reg"}, v, 32'h0);
    check({tag, " irq_o"}, {31'h0, irq_o}, 32'h0);
    check({tag, " fiq_o"}, {31'h0, fiq_o}, 32'h0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_checks("R1 power-on");

    for (int i = 0; i < NROW; i++) begin
      @(negedge clk);
      hw_src_i = TBL[i].hw; err_stat_i = TBL[i].err;
      if (TBL[i].wr) bus_write(TBL[i].waddr, TBL[i].wdata);
      bus_read(TBL[i].raddr, v);
      check($sformatf("R%0d row %0d read", TBL[i].req, i), v, TBL[i].exp);
      check($sformatf("R%0d row %0d irq_o", TBL[i].req, i), {31'h0, irq_o}, {31'h0, TBL[i].eirq});
      check($sformatf("R%0d row %0d fiq_o", TBL[i].req, i), {31'h0, fiq_o}, {31'h0, TBL[i].efiq});
    end

    // R6: output follows a source change within the same cycle, no write
    @(negedge clk);
    hw_src_i = 32'h0; err_stat_i = 8'h0;
    bus_write(8'h0C, 32'h0000_2000);
    hw_src_i = 32'h0000_2000; #1;
    check("R6 fiq follows source", {31'h0, fiq_o}, 32'h1);
    hw_src_i = 32'h0; #1;
    check("R6 fiq drops with source", {31'h0, fiq_o}, 32'h0);

    // R8: reserved-only set leaves irq mask unchanged at bit 0 only
    bus_write(8'h10, 32'hF0F0_0800);
    bus_read(8'h10, v);
    check("R8 reserved set ignored", v, 32'h0000_0001);

    // R1: reset in the middle of activity
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_write(8'h54, 32'h1);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_checks("R1 mid-run");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

endmodule